// File: doc/BRIEF.md
# PCI INTx Interrupt Line Router

This block takes interrupt events from PCI functions and turns them into levels on a 64-bit interrupt request vector. Each event names the source that raised it, whether the source is asserting or releasing its INTx wire, the slot number and bus number of the device, and the interrupt pin byte read from configuration space. A fixed board-wiring rule folds slot, bus and pin into a 6-bit bit index. The interrupt line byte that software writes into configuration space plays no part in the choice, so it has no input here.

The router keeps a small table with one entry per source. An entry holds whether the source is asserting and which bit it drives. The output vector is the OR of all active entries, so two sources wired onto the same bit keep it high until both have released it. A function whose pin byte is zero has no INTx wire: its events change nothing, and the handled flag stays low for them.

Top module: `pci_intx_router`

## Requirements
- R1: After reset `irq_vec` is all zeros and `ev_handled` is low.
- R2: The bit index of a routed event is ((ev_slot + 1) * 4 + ev_bus * 16 + ((ev_pin - 1) AND 3)) modulo 64, with ev_slot 5 bits wide and ev_bus 2 bits wide. Examples: slot 0, bus 0, pin 1 gives bit 4; slot 15, bus 0, pin 1 wraps to bit 0; slot 31, bus 3, pin 4 gives bit 51.
- R3: Pin byte encoding: 1 selects INTA, 2 INTB, 3 INTC, 4 INTD. A pin byte of 0 means no interrupt: the event leaves `irq_vec` unchanged and `ev_handled` low.
- R4: With `ev_valid` high, `ev_assert` = 1 marks an assert. The selected bit of `irq_vec` is high in the cycle after the event.
- R5: `ev_assert` = 0 marks a deassert. It withdraws that source's contribution, and its bit drops in the cycle after the event unless another source still drives it.
- R6: Each bit of `irq_vec` is the OR of the asserted levels of every source mapped to it, so at most NUM_SRC bits are high at once.
- R7: `ev_handled` is high for exactly the cycle after an event with a nonzero pin byte, and low otherwise.
- R8: A source that asserts again with a different slot, bus or pin moves its contribution to the new bit, and its old bit drops unless another source holds it.
- R9: Pin bytes above 4 are reduced by the same AND 3 rule: pin 5 routes like pin 1 and pin 8 like pin 4.
- R10: A cycle with `ev_valid` low leaves `irq_vec` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_src | input | SRC_W (3) | Index of the source table entry the event belongs to |
| ev_assert | input | 1 | 1 = assert, 0 = deassert |
| ev_slot | input | SLOT_W (5) | Device slot number |
| ev_bus | input | BUS_W (2) | Bus number |
| ev_pin | input | 8 | Interrupt pin byte from configuration space |
| irq_vec | output | VEC_W (64) | Interrupt request level vector |
| ev_handled | output | 1 | High the cycle after a routed event |

## Verification
On every cycle the assertions check the index formula against an assert event, that zero-pin events and idle cycles leave the vector untouched, that the handled flag tracks routed events, and that no more bits are high than there are sources. The OR behaviour of shared bits, the release of a bit only after its last holder deasserts, and the move of a source from one bit to another depend on the history of several events, so only the bench's directed sequences and its randomised event stream, compared against a reference model of the source table, show them.

// File: rtl/pci_intx_router_pkg.sv
package pci_intx_router_pkg;

  typedef enum logic {
    EV_DEASSERT = 1'b0,
    EV_ASSERT   = 1'b1
  } intx_ev_e;

  localparam int PIN_BYTE_W = 8;
  localparam int SLOT_STRIDE_SHIFT = 2;
  localparam int BUS_STRIDE_SHIFT = 4;

endpackage

// File: rtl/intx_index_calc.sv
module intx_index_calc
  import pci_intx_router_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int BUS_W  = 2,
  parameter int IDX_W  = 6
) (
  input  logic [SLOT_W-1:0]     slot_i,
  input  logic [BUS_W-1:0]      bus_i,
  input  logic [PIN_BYTE_W-1:0] pin_i,
  output logic [IDX_W-1:0]      idx_o,
  output logic                  pin_present_o
);

  localparam int SUM_W = SLOT_W + BUS_W + BUS_STRIDE_SHIFT + 2;

  logic [SUM_W-1:0] slot_term;
  logic [SUM_W-1:0] bus_term;
  logic [SUM_W-1:0] intx_term;
  logic [SUM_W-1:0] sum;
  logic [1:0]       intx_sel;

  always_comb begin
    intx_sel      = pin_i[1:0] - 2'd1;
    slot_term     = (SUM_W'(slot_i) + SUM_W'(1)) << SLOT_STRIDE_SHIFT;
    bus_term      = SUM_W'(bus_i) << BUS_STRIDE_SHIFT;
    intx_term     = SUM_W'(intx_sel);
    sum           = slot_term + bus_term + intx_term;
    idx_o         = sum[IDX_W-1:0];
    pin_present_o = (pin_i != '0);
  end

endmodule

// File: rtl/intx_src_entry.sv
module intx_src_entry #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en_i,
  input  logic             upd_level_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o
);

  logic             active_d, active_q;
  logic [IDX_W-1:0] idx_d, idx_q;
  logic             idx_en;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    idx_en   = upd_en_i && upd_level_i;
    if (upd_en_i) begin
      active_d = upd_level_i;
    end
    if (idx_en) begin
      idx_d = upd_idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (upd_en_i) begin
      active_q <= active_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;

endmodule

// File: rtl/intx_vec_merge.sv
module intx_vec_merge #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 6,
  parameter int VEC_W   = 64
) (
  input  logic [NUM_SRC-1:0]       active_i,
  input  logic [NUM_SRC*IDX_W-1:0] idx_i,
  output logic [VEC_W-1:0]         vec_o
);

  logic [VEC_W-1:0] contrib [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_contrib
    always_comb begin
      contrib[g] = '0;
      if (active_i[g]) begin
        contrib[g] = VEC_W'(1) << idx_i[g*IDX_W +: IDX_W];
      end
    end
  end

  always_comb begin
    vec_o = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      vec_o = vec_o | contrib[s];
    end
  end

endmodule

// File: rtl/pci_intx_router.sv
module pci_intx_router
  import pci_intx_router_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  parameter int SLOT_W  = 5,
  parameter int BUS_W   = 2,
  parameter int VEC_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [SRC_W-1:0]  ev_src,
  input  logic              ev_assert,
  input  logic [SLOT_W-1:0] ev_slot,
  input  logic [BUS_W-1:0]  ev_bus,
  input  logic [7:0]        ev_pin,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              ev_handled
);

  localparam int IDX_W = $clog2(VEC_W);

  logic [IDX_W-1:0]         route_idx;
  logic                     pin_present;
  logic                     routed;
  logic [NUM_SRC-1:0]       src_active;
  logic [NUM_SRC*IDX_W-1:0] src_idx;
  logic                     handled_d, handled_q;

  intx_index_calc #(
    .SLOT_W (SLOT_W),
    .BUS_W  (BUS_W),
    .IDX_W  (IDX_W)
  ) u_calc (
    .slot_i        (ev_slot),
    .bus_i         (ev_bus),
    .pin_i         (ev_pin),
    .idx_o         (route_idx),
    .pin_present_o (pin_present)
  );

  assign routed = ev_valid && pin_present;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic sel;
    assign sel = routed && (ev_src == SRC_W'(g));

    intx_src_entry #(
      .IDX_W (IDX_W)
    ) u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd_en_i    (sel),
      .upd_level_i (ev_assert == EV_ASSERT),
      .upd_idx_i   (route_idx),
      .active_o    (src_active[g]),
      .idx_o       (src_idx[g*IDX_W +: IDX_W])
    );
  end

  intx_vec_merge #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W),
    .VEC_W   (VEC_W)
  ) u_merge (
    .active_i (src_active),
    .idx_i    (src_idx),
    .vec_o    (irq_vec)
  );

  always_comb begin
    handled_d = routed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      handled_q <= 1'b0;
    end else begin
      handled_q <= handled_d;
    end
  end

  assign ev_handled = handled_q;

endmodule

// File: rtl/pci_intx_router_chk.sv
module pci_intx_router_chk #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3,
  parameter int SLOT_W  = 5,
  parameter int BUS_W   = 2,
  parameter int VEC_W   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic [SRC_W-1:0]  ev_src,
  input logic              ev_assert,
  input logic [SLOT_W-1:0] ev_slot,
  input logic [BUS_W-1:0]  ev_bus,
  input logic [7:0]        ev_pin,
  input logic [VEC_W-1:0]  irq_vec,
  input logic              ev_handled
);

  int exp_bit;

  always_comb begin
    exp_bit = ((int'(ev_slot) + 1) * 4 + int'(ev_bus) * 16
               + ((int'(ev_pin) + 3) % 4)) % VEC_W;
  end

  // R2, R4: an assert lands on the bit given by the wiring rule
  p_assert_sets_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin != 8'd0 && ev_assert) |=> irq_vec[$past(exp_bit)]);

  // R3: a zero pin byte changes nothing
  p_zero_pin_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin == 8'd0) |=> ($stable(irq_vec) && !ev_handled));

  // R7: handled follows a routed event
  p_handled_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_pin != 8'd0) |=> ev_handled);

  // R10: idle cycles hold the vector
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> ($stable(irq_vec) && !ev_handled));

  // R6: no more bits high than there are sources
  p_bit_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_vec) <= NUM_SRC);

  logic unused_src;
  assign unused_src = ^ev_src;

endmodule

bind pci_intx_router pci_intx_router_chk #(
  .NUM_SRC (NUM_SRC),
  .SRC_W   (SRC_W),
  .SLOT_W  (SLOT_W),
  .BUS_W   (BUS_W),
  .VEC_W   (VEC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_valid   (ev_valid),
  .ev_src     (ev_src),
  .ev_assert  (ev_assert),
  .ev_slot    (ev_slot),
  .ev_bus     (ev_bus),
  .ev_pin     (ev_pin),
  .irq_vec    (irq_vec),
  .ev_handled (ev_handled)
);

// File: tb/tb_pci_intx_router.sv
`timescale 1ns/1ps
module tb_pci_intx_router;

  localparam int NUM_SRC = 8;
  localparam int SRC_W   = 3;
  localparam int VEC_W   = 64;

  logic              clk;
  logic              rst_n;
  logic              ev_valid;
  logic [SRC_W-1:0]  ev_src;
  logic              ev_assert;
  logic [4:0]        ev_slot;
  logic [1:0]        ev_bus;
  logic [7:0]        ev_pin;
  logic [VEC_W-1:0]  irq_vec;
  logic              ev_handled;

  int n_checks;
  int n_fails;
  bit done;

  bit       m_act [NUM_SRC];
  int       m_idx [NUM_SRC];

  pci_intx_router #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .VEC_W(VEC_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_src     (ev_src),
    .ev_assert  (ev_assert),
    .ev_slot    (ev_slot),
    .ev_bus     (ev_bus),
    .ev_pin     (ev_pin),
    .irq_vec    (irq_vec),
    .ev_handled (ev_handled)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int route_bit(int slot, int bus, int pin);
    int s, b, x;
    s = slot % 32;
    b = bus % 4;
    x = (pin - 1) & 3;
    return ((s + 1) * 4 + b * 16 + x) % 64;
  endfunction

  function automatic logic [VEC_W-1:0] model_vec();
    logic [VEC_W-1:0] v;
    v = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (m_act[s]) v[m_idx[s]] = 1'b1;
    end
    return v;
  endfunction

  task automatic check_vec(string tag, logic [VEC_W-1:0] exp);
    n_checks++;
    if (irq_vec !== exp) begin
      n_fails++;
      $display("FAIL %s irq_vec actual=%h expected=%h", tag, irq_vec, exp);
    end
  endtask

  task automatic check_hnd(string tag, logic exp);
    n_checks++;
    if (ev_handled !== exp) begin
      n_fails++;
      $display("FAIL %s ev_handled actual=%b expected=%b", tag, ev_handled, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic send(string tag, int src, bit asrt, int slot, int bus, int pin);
    ev_valid  = 1'b1;
    ev_src    = SRC_W'(src);
    ev_assert = asrt;
    ev_slot   = 5'(slot);
    ev_bus    = 2'(bus);
    ev_pin    = 8'(pin);
    if (pin != 0) begin
      m_act[src] = asrt;
      if (asrt) m_idx[src] = route_bit(slot, bus, pin);
    end
    @(negedge clk);
    ev_valid = 1'b0;
    check_vec(tag, model_vec());
    check_hnd(tag, pin != 0);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    check_vec(tag, model_vec());
    check_hnd(tag, 1'b0);
  endtask

  function automatic logic [VEC_W-1:0] one_bit(int b);
    logic [VEC_W-1:0] v;
    v = '0;
    v[b] = 1'b1;
    return v;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1357));
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      m_act[s] = 1'b0;
      m_idx[s] = 0;
    end
    rst_n     = 1'b0;
    ev_valid  = 1'b0;
    ev_src    = '0;
    ev_assert = 1'b0;
    ev_slot   = '0;
    ev_bus    = '0;
    ev_pin    = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_vec("R1 reset", '0);
    check_hnd("R1 reset", 1'b0);
    rst_n = 1'b1;
    idle("R1 after release");

    // R2, R4: slot 0 bus 0 INTA -> bit 4
    send("R2 R4 slot0 INTA", 0, 1'b1, 0, 0, 1);
    check_vec("R2 bit4", one_bit(4));
    // R5: deassert clears
    send("R5 deassert", 0, 1'b0, 0, 0, 1);
    check_vec("R5 cleared", '0);
    // R2: wrap to bit 0
    send("R2 wrap", 1, 1'b1, 15, 0, 1);
    check_vec("R2 bit0", one_bit(0));
    send("R5 clr wrap", 1, 1'b0, 15, 0, 1);
    // R2: top corner slot 31 bus 3 INTD -> bit 51
    send("R2 corner", 2, 1'b1, 31, 3, 4);
    check_vec("R2 bit51", one_bit(51));
    // R3: zero pin byte ignored, both assert and deassert
    send("R3 zero pin assert", 3, 1'b1, 5, 1, 0);
    send("R3 zero pin deassert", 2, 1'b0, 31, 3, 0);
    check_vec("R3 unchanged", one_bit(51));
    // R10: idle holds
    idle("R10 idle hold");
    idle("R10 idle hold 2");
    send("R5 clr corner", 2, 1'b0, 31, 3, 4);
    // R6: two sources on one bit
    send("R6 src4 on", 4, 1'b1, 3, 2, 2);
    send("R6 src5 same", 5, 1'b1, 3, 2, 2);
    send("R6 src4 off", 4, 1'b0, 3, 2, 2);
    check_vec("R6 still held", one_bit(route_bit(3, 2, 2)));
    send("R6 src5 off", 5, 1'b0, 3, 2, 2);
    check_vec("R6 released", '0);
    // R8: move
    send("R8 src6 first", 6, 1'b1, 7, 1, 3);
    send("R8 src6 moved", 6, 1'b1, 9, 0, 2);
    check_vec("R8 moved", one_bit(route_bit(9, 0, 2)));
    send("R8 src6 off", 6, 1'b0, 9, 0, 2);
    // R9: pin 5 acts like pin 1, pin 8 like pin 4
    send("R9 pin5", 7, 1'b1, 2, 1, 5);
    check_vec("R9 pin5 bit", one_bit(route_bit(2, 1, 1)));
    send("R9 pin8", 7, 1'b1, 2, 1, 8);
    check_vec("R9 pin8 bit", one_bit(route_bit(2, 1, 4)));
    send("R9 off", 7, 1'b0, 2, 1, 8);

    // random stream covering R2 R4 R5 R6 R8 R3 R7
    for (int i = 0; i < 600; i++) begin
      int src, slot, bus, pin;
      bit asrt;
      src  = $urandom_range(NUM_SRC - 1);
      slot = $urandom_range(31);
      bus  = $urandom_range(3);
      asrt = ($urandom_range(2) != 0);
      pin  = ($urandom_range(7) == 0) ? 0 : $urandom_range(8, 1);
      if ($urandom_range(4) == 0) idle("R10 random idle");
      send("R7 random", src, asrt, slot, bus, pin);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule